// File: doc/BRIEF.md
# Dual Register Set Fallback Controller

This block keeps two banks of clock configuration registers, called X and Y. At any moment one bank is active and its contents drive the downstream clock logic through a flattened output vector. The other bank is idle, and it is the only bank the host can write or read. At reset bank Y is active, so the host can prepare bank X while Y runs the clocks.

A one-byte command port starts the role changes. A plain swap (GO) moves activity to the idle bank. A forced fallback (FORCE) creates a fallback event, which swaps the banks and raises a sticky fallback flag. An external fallback input creates the same event. The flag stays set until a recovery command (CLEAR) swaps the banks back. The command port also starts a bulk copy that loads the whole active bank into the idle bank in a single cycle. Any of the three swap commands can take effect at once or wait for the next 8 kHz frame pulse. Command bits hold no value after the write, so each command acts once.

Top module: `clk_bank_ctl`

## Requirements
- R1: After reset bank Y is active (`act_is_x` = 0), `fallback_flag` = 0, `cmd_pending` = 0, both banks hold zero, and host accesses go to bank X.
- R2: Command byte fields are bit0 GO, bit1 CLEAR, bit2 FORCE, bit3 COPY and bit7 frame-wait (1 = wait for frame). Bits 6:4 are ignored. A command acts only in the cycle it is written, and the active bank does not change again on later idle cycles.
- R3: An immediate GO (bit7 = 0) swaps the active bank, and the change is visible on the clock edge that takes the write.
- R4: A fallback event (an immediate FORCE, or `fallback_in` high for a cycle) swaps the banks and sets `fallback_flag` when the flag is clear. When the flag is already set, the event changes nothing.
- R5: An immediate CLEAR with `fallback_flag` set swaps the banks and clears the flag. With the flag clear, it has no effect.
- R6: A swap command written with bit7 = 1 does not act at once. It raises `cmd_pending` and executes on the first `frame_pulse` after the write cycle, and `cmd_pending` then drops.
- R7: Only one frame-wait command is held at a time. A later frame-wait write replaces the held one.
- R8: When several swap bits are written together, FORCE takes precedence over CLEAR, and CLEAR over GO. Only the winner acts.
- R9: COPY loads every register of the active bank into the idle bank in one cycle. It always acts at once, whatever bit7 holds.
- R10: Host writes and reads (`host_rdata`, combinational) address the idle bank and follow it across every swap.
- R11: `act_cfg` shows the active bank (register i at bits i*DW +: DW). It changes only when the banks swap, never on a host write.
- R12: A held CLEAR that reaches its frame pulse while `fallback_flag` is clear is consumed without any swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Write strobe for the idle bank |
| host_addr | input | $clog2(NREG) | Register index in the idle bank |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Idle bank register at host_addr |
| cmd_we | input | 1 | Command byte strobe |
| cmd_wdata | input | 8 | Command byte |
| frame_pulse | input | 1 | One-cycle 8 kHz frame marker |
| fallback_in | input | 1 | External fallback event |
| act_is_x | output | 1 | 1 when bank X is active |
| act_cfg | output | NREG*DW | Active bank contents, flattened |
| fallback_flag | output | 1 | Sticky fallback indicator |
| cmd_pending | output | 1 | A frame-wait command is held |

## Verification
Assertions check on every cycle that the active bank and its output vector stay put when no command, frame or fallback input is present, and that a held command changes only on a command write or a frame pulse. They also check that a fallback input always leaves the flag set, that a repeated event while the flag is set leaves the bank choice unchanged, and that the flag drops only after a recovery command. The directed scenarios cover the remaining behaviour: command priority, replacement of a held command, the bulk copy, a recovery command with no fallback pending, and host accesses following the idle bank across swaps.

// File: rtl/clk_bank_ctl.sv
module clk_bank_ctl #(
  parameter int NREG = 8,
  parameter int DW   = 16,
  localparam int AW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 host_we,
  input  logic [AW-1:0]        host_addr,
  input  logic [DW-1:0]        host_wdata,
  output logic [DW-1:0]        host_rdata,
  input  logic                 cmd_we,
  input  logic [7:0]           cmd_wdata,
  input  logic                 frame_pulse,
  input  logic                 fallback_in,
  output logic                 act_is_x,
  output logic [NREG*DW-1:0]   act_cfg,
  output logic                 fallback_flag,
  output logic                 cmd_pending
);

  typedef enum logic [1:0] {K_NONE, K_GO, K_CLR, K_FRC} kind_t;

  logic [DW-1:0] bank_x [NREG];
  logic [DW-1:0] bank_y [NREG];
  logic          x_q, flag_q;
  kind_t         pend_q;

  kind_t sel, eff;
  logic  any_swap, imm, wait_wr, fire, evt, swap, copy;
  logic  unused_hi;

  assign unused_hi = ^cmd_wdata[6:4];

  assign any_swap = |cmd_wdata[2:0];
  assign imm      = cmd_we && !cmd_wdata[7] && any_swap;
  assign wait_wr  = cmd_we &&  cmd_wdata[7] && any_swap;
  assign copy     = cmd_we &&  cmd_wdata[3];
  assign fire     = frame_pulse && (pend_q != K_NONE) && !imm && !fallback_in;

  always_comb begin
    if (cmd_wdata[2])      sel = K_FRC;
    else if (cmd_wdata[1]) sel = K_CLR;
    else if (cmd_wdata[0]) sel = K_GO;
    else                   sel = K_NONE;
  end

  assign eff  = imm ? sel : (fire ? pend_q : K_NONE);
  assign evt  = fallback_in || (eff == K_FRC);
  assign swap = evt ? !flag_q : ((eff == K_GO) || (eff == K_CLR && flag_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q    <= 1'b0;
      flag_q <= 1'b0;
      pend_q <= K_NONE;
    end else begin
      x_q <= x_q ^ swap;
      if (evt)                flag_q <= 1'b1;
      else if (eff == K_CLR)  flag_q <= 1'b0;
      if (wait_wr)            pend_q <= sel;
      else if (fire)          pend_q <= K_NONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        bank_x[i] <= '0;
        bank_y[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (copy) begin
          if (x_q) bank_y[i] <= bank_x[i];
          else     bank_x[i] <= bank_y[i];
        end else if (host_we && host_addr == AW'(i)) begin
          if (x_q) bank_y[i] <= host_wdata;
          else     bank_x[i] <= host_wdata;
        end
      end
    end
  end

  assign host_rdata = x_q ? bank_y[host_addr] : bank_x[host_addr];

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign act_cfg[g*DW +: DW] = x_q ? bank_x[g] : bank_y[g];
  end

  assign act_is_x      = x_q;
  assign fallback_flag = flag_q;
  assign cmd_pending   = (pend_q != K_NONE);

  a_r11_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_we && !frame_pulse && !fallback_in) |=> ($stable(act_is_x) && $stable(act_cfg)));

  a_r4_event_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    fallback_in |=> fallback_flag);

  a_r4_event_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (fallback_flag && fallback_in && !cmd_we) |=> $stable(act_is_x));

  a_r5_flag_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fallback_flag) |-> ($past(cmd_we && cmd_wdata[1]) || $past(frame_pulse && cmd_pending)));

  a_r6_pending_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_we && !frame_pulse) |=> $stable(cmd_pending));

endmodule

// File: tb/clk_bank_ctl_tb.sv
module clk_bank_ctl_tb;
  localparam int NREG = 8;
  localparam int DW   = 16;
  localparam int AW   = $clog2(NREG);

  logic clk = 0, rst_n = 0;
  logic host_we = 0, cmd_we = 0, frame_pulse = 0, fallback_in = 0;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0, host_rdata;
  logic [7:0] cmd_wdata = '0;
  logic act_is_x, fallback_flag, cmd_pending;
  logic [NREG*DW-1:0] act_cfg;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  clk_bank_ctl #(.NREG(NREG), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .cmd_we(cmd_we),
    .cmd_wdata(cmd_wdata), .frame_pulse(frame_pulse), .fallback_in(fallback_in),
    .act_is_x(act_is_x), .act_cfg(act_cfg), .fallback_flag(fallback_flag),
    .cmd_pending(cmd_pending));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic cmd(input logic [7:0] b);
    @(negedge clk); cmd_we = 1; cmd_wdata = b;
    @(negedge clk); cmd_we = 0; cmd_wdata = '0;
  endtask

  task automatic hwrite(input int a, input logic [DW-1:0] d);
    @(negedge clk); host_we = 1; host_addr = AW'(a); host_wdata = d;
    @(negedge clk); host_we = 0;
  endtask

  task automatic frame();
    @(negedge clk); frame_pulse = 1;
    @(negedge clk); frame_pulse = 0;
  endtask

  task automatic ext_fb();
    @(negedge clk); fallback_in = 1;
    @(negedge clk); fallback_in = 0;
  endtask

  function automatic logic [DW-1:0] word(input int i);
    return act_cfg[i*DW +: DW];
  endfunction

  task automatic t_reset();
    do_reset();
    chk("R1 act_is_x", act_is_x, 0);
    chk("R1 flag", fallback_flag, 0);
    chk("R1 pending", cmd_pending, 0);
    chk("R1 act_cfg zero", (act_cfg == '0), 1);
  endtask

  task automatic t_host_go();
    do_reset();
    hwrite(2, 16'h1234);
    host_addr = AW'(2); #1;
    chk("R10 read idle X", host_rdata, 16'h1234);
    chk("R11 active unchanged by write", word(2), 0);
    cmd(8'h01);
    chk("R3 go swaps", act_is_x, 1);
    chk("R1 host wrote X, now active", word(2), 16'h1234);
    host_addr = AW'(2); #1;
    chk("R10 read follows to Y", host_rdata, 0);
    repeat (3) @(negedge clk);
    chk("R2 self clearing", act_is_x, 1);
    cmd(8'h70);
    chk("R2 high bits ignored", act_is_x, 1);
  endtask

  task automatic t_fallback();
    do_reset();
    cmd(8'h04);
    chk("R4 force swaps", act_is_x, 1);
    chk("R4 force sets flag", fallback_flag, 1);
    cmd(8'h04);
    chk("R4 force ignored when flag set", act_is_x, 1);
    ext_fb();
    chk("R4 external ignored when flag set", act_is_x, 1);
    cmd(8'h02);
    chk("R5 clear swaps back", act_is_x, 0);
    chk("R5 clear drops flag", fallback_flag, 0);
    cmd(8'h02);
    chk("R5 clear without flag no effect", act_is_x, 0);
    do_reset();
    ext_fb();
    chk("R4 external swaps", act_is_x, 1);
    chk("R4 external sets flag", fallback_flag, 1);
  endtask

  task automatic t_sync();
    do_reset();
    cmd(8'h81);
    chk("R6 held go no swap", act_is_x, 0);
    chk("R6 pending raised", cmd_pending, 1);
    repeat (4) @(negedge clk);
    chk("R6 waits for frame", act_is_x, 0);
    frame();
    chk("R6 go at frame", act_is_x, 1);
    chk("R6 pending cleared", cmd_pending, 0);
    cmd(8'h81);
    cmd(8'h84);
    frame();
    chk("R7 replaced by force", act_is_x, 0);
    chk("R7 force flag", fallback_flag, 1);
    do_reset();
    cmd(8'h82);
    frame();
    chk("R12 held clear no swap", act_is_x, 0);
    chk("R12 held clear consumed", cmd_pending, 0);
  endtask

  task automatic t_priority();
    do_reset();
    cmd(8'h07);
    chk("R8 force wins act", act_is_x, 1);
    chk("R8 force wins flag", fallback_flag, 1);
    cmd(8'h03);
    chk("R8 clear beats go act", act_is_x, 0);
    chk("R8 clear beats go flag", fallback_flag, 0);
  endtask

  task automatic t_copy();
    do_reset();
    hwrite(1, 16'hAAAA);
    hwrite(7, 16'h5A5A);
    cmd(8'h01);
    chk("R9 precondition", word(1), 16'hAAAA);
    cmd(8'h88);
    chk("R9 copy no swap", act_is_x, 1);
    host_addr = AW'(1); #1;
    chk("R9 copy reg1 into Y", host_rdata, 16'hAAAA);
    host_addr = AW'(7); #1;
    chk("R9 copy reg7 into Y", host_rdata, 16'h5A5A);
    chk("R9 nothing pending", cmd_pending, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_host_go();
    t_fallback();
    t_sync();
    t_priority();
    t_copy();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule